// File: doc/BRIEF.md
# Table-Driven Serial Shift Clock Divider

This block derives the shift clock for a serial memory interface from a reference clock. A 4-bit divider code selects how many reference-clock ticks the shift clock spends high and how many it spends low. The ratios do not follow a formula. They come from a fixed table, so odd ratios give a duty cycle close to 50%, with the high phase one tick longer. One code passes the reference clock straight through without dividing it. Alongside the clock, the block drives a one-cycle strobe at each rising edge and at each falling edge, which the shifter uses to time its data.

The divider code is held in a register that accepts a single write. The same write also stores a companion boot-control bit. Power-on reset loads the slowest code (divide by 67) and reopens the register for one write. A soft reset restarts the clock generator but keeps the stored code and bit. A change of code never cuts a phase short: the generator finishes the low phase in progress before it picks up the new code.

Top module: `spi_sclk_div`

## Requirements
- R1: With code 0000 active, `sclk` equals `clk_ref` and `sclk_rise` and `sclk_fall` are both held at 1.
- R2: Codes 0001 to 0111 give these high/low tick counts: 1/1, 2/1, 2/2, 3/2, 4/3, 5/5, 7/6.
- R3: Codes 1000 to 1110 give these high/low tick counts: 7/7, 9/8, 13/12, 17/16, 17/17, 25/25, 34/33.
- R4: After power-on reset, `div_code` reads 1110 (34/33 ticks), `boot_flag` reads 0, and `sclk` is low while reset is held.
- R5: Only the first `wr_en` pulse after power-on reset is accepted. Later writes change neither `div_code` nor the output timing. Soft reset keeps the stored values. Power-on reset restores the default and accepts one new write.
- R6: A write takes the code from `wr_data[3:0]` and the boot-control bit from `wr_data[4]` in the same cycle. The bit appears on `boot_flag`.
- R7: Writing the reserved code 1111 stores 1110 and gives the 34/33 timing.
- R8: A newly written code takes effect only at the end of the current low phase. The high and low phases in progress keep the counts of the old code.
- R9: Outside bypass, `sclk_rise` is 1 only in the first reference cycle of each high phase, and `sclk_fall` is 1 only in the first cycle of each low phase. The two strobes are never 1 together.
- R10: While `soft_rst` is 1, `sclk` is low (outside bypass). `sclk` rises at the first `clk_ref` edge after `soft_rst` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset of the clock generator, synchronous, active high |
| wr_en | input | 1 | Write strobe for the configuration register |
| wr_data | input | 5 | [4] boot-control bit, [3:0] divider code |
| sclk | output | 1 | Shift clock |
| sclk_rise | output | 1 | One-cycle strobe on each rising shift-clock edge |
| sclk_fall | output | 1 | One-cycle strobe on each falling shift-clock edge |
| div_code | output | 4 | Stored divider code |
| boot_flag | output | 1 | Stored boot-control bit |

## Verification
Every cycle, the assertions check the following: each strobe lines up with the matching edge of the registered clock, the two strobes never fire together, the phase counter never reaches zero outside bypass, and the active code changes only after a low phase. They also check that the locked register holds still. The exact tick counts for each code, the bypass waveform, the rejection of a second write, and the way a code change mid-phase lets the old high and low phases finish can only be shown by the bench. It measures phase widths at the ports and does this separately after each power-on reset.

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int CNT_W    = 6,
  parameter int DEF_CODE = 14
) (
  input  logic       clk_ref,
  input  logic       por_n,
  input  logic       soft_rst,
  input  logic       wr_en,
  input  logic [4:0] wr_data,
  output logic       sclk,
  output logic       sclk_rise,
  output logic       sclk_fall,
  output logic [3:0] div_code,
  output logic       boot_flag
);

  localparam logic [3:0]       RSVD  = 4'hF;
  localparam logic [3:0]       DEFC  = 4'(DEF_CODE);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  function automatic logic [CNT_W-1:0] hi_ticks(input logic [3:0] c);
    case (c)
      4'h1: hi_ticks = CNT_W'(1);
      4'h2: hi_ticks = CNT_W'(2);
      4'h3: hi_ticks = CNT_W'(2);
      4'h4: hi_ticks = CNT_W'(3);
      4'h5: hi_ticks = CNT_W'(4);
      4'h6: hi_ticks = CNT_W'(5);
      4'h7: hi_ticks = CNT_W'(7);
      4'h8: hi_ticks = CNT_W'(7);
      4'h9: hi_ticks = CNT_W'(9);
      4'hA: hi_ticks = CNT_W'(13);
      4'hB: hi_ticks = CNT_W'(17);
      4'hC: hi_ticks = CNT_W'(17);
      4'hD: hi_ticks = CNT_W'(25);
      default: hi_ticks = CNT_W'(34);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] lo_ticks(input logic [3:0] c);
    case (c)
      4'h1: lo_ticks = CNT_W'(1);
      4'h2: lo_ticks = CNT_W'(1);
      4'h3: lo_ticks = CNT_W'(2);
      4'h4: lo_ticks = CNT_W'(2);
      4'h5: lo_ticks = CNT_W'(3);
      4'h6: lo_ticks = CNT_W'(5);
      4'h7: lo_ticks = CNT_W'(6);
      4'h8: lo_ticks = CNT_W'(7);
      4'h9: lo_ticks = CNT_W'(8);
      4'hA: lo_ticks = CNT_W'(12);
      4'hB: lo_ticks = CNT_W'(16);
      4'hC: lo_ticks = CNT_W'(17);
      4'hD: lo_ticks = CNT_W'(25);
      default: lo_ticks = CNT_W'(33);
    endcase
  endfunction

  logic [3:0]       code_r, active;
  logic             flag_r, locked;
  logic             sclk_q, rise_q, fall_q;
  logic [CNT_W-1:0] cnt;

  wire [3:0] wr_code = (wr_data[3:0] == RSVD) ? DEFC : wr_data[3:0];
  wire       bypass  = (active == 4'h0);
  wire       end_lo  = bypass || (!sclk_q && cnt == ONE);
  wire       end_hi  = !bypass && sclk_q && cnt == ONE;

  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n) begin
      code_r <= DEFC;
      flag_r <= 1'b0;
      locked <= 1'b0;
    end else if (wr_en && !locked) begin
      code_r <= wr_code;
      flag_r <= wr_data[4];
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n) begin
      active <= DEFC;
      sclk_q <= 1'b0;
      cnt    <= ONE;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (soft_rst) begin
      sclk_q <= 1'b0;
      cnt    <= ONE;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (end_lo) begin
        active <= code_r;
        if (code_r == 4'h0) begin
          sclk_q <= 1'b0;
          cnt    <= ONE;
        end else begin
          sclk_q <= 1'b1;
          cnt    <= hi_ticks(code_r);
          rise_q <= 1'b1;
        end
      end else if (end_hi) begin
        sclk_q <= 1'b0;
        cnt    <= lo_ticks(active);
        fall_q <= 1'b1;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign sclk      = bypass ? clk_ref : sclk_q;
  assign sclk_rise = bypass | rise_q;
  assign sclk_fall = bypass | fall_q;
  assign div_code  = code_r;
  assign boot_flag = flag_r;

  AST_BYPASS_IDLE: assert property (@(posedge clk_ref) disable iff (!por_n)
    bypass |-> !sclk_q); // R1
  AST_CNT_NZ: assert property (@(posedge clk_ref) disable iff (!por_n)
    !bypass |-> cnt != '0); // R2
  AST_LOCK_HOLD: assert property (@(posedge clk_ref) disable iff (!por_n)
    locked |=> $stable(code_r) && $stable(flag_r)); // R5
  AST_CODE_SWITCH: assert property (@(posedge clk_ref) disable iff (!por_n)
    !$stable(active) |-> !$past(sclk_q)); // R8
  AST_RISE_EDGE: assert property (@(posedge clk_ref) disable iff (!por_n)
    rise_q |-> sclk_q && !$past(sclk_q)); // R9
  AST_FALL_EDGE: assert property (@(posedge clk_ref) disable iff (!por_n)
    fall_q |-> !sclk_q && $past(sclk_q)); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk_ref) disable iff (!por_n)
    !(rise_q && fall_q)); // R9

endmodule

// File: tb/sim_spi_sclk_div.sv
module sim_spi_sclk_div;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       soft_rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic       sclk, rise, fall;
  logic [3:0] div_code;
  logic       boot_flag;
  int         applied = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  spi_sclk_div u0 (
    .clk_ref(clk), .por_n(por_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_data(wr_data), .sclk(sclk), .sclk_rise(rise), .sclk_fall(fall),
    .div_code(div_code), .boot_flag(boot_flag)
  );

  // {code, high ticks, low ticks}; 0/0 marks bypass
  localparam logic [15:0] VEC [16] = '{
    {4'h0, 6'd0,  6'd0 }, {4'h1, 6'd1,  6'd1 }, {4'h2, 6'd2,  6'd1 },
    {4'h3, 6'd2,  6'd2 }, {4'h4, 6'd3,  6'd2 }, {4'h5, 6'd4,  6'd3 },
    {4'h6, 6'd5,  6'd5 }, {4'h7, 6'd7,  6'd6 }, {4'h8, 6'd7,  6'd7 },
    {4'h9, 6'd9,  6'd8 }, {4'hA, 6'd13, 6'd12}, {4'hB, 6'd17, 6'd16},
    {4'hC, 6'd17, 6'd17}, {4'hD, 6'd25, 6'd25}, {4'hE, 6'd34, 6'd33},
    {4'hF, 6'd34, 6'd33}
  };

  task automatic check(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic power_on();
    @(negedge clk);
    soft_rst = 1'b1;
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic write_cfg(input logic [4:0] d);
    @(negedge clk);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // from the next rise strobe, count high and low samples; sok=1 if strobes fit
  task automatic measure(output int h, output int l, output int sok);
    int guard = 0;
    sok = 1;
    do begin @(negedge clk); guard++; end while (!rise && guard < 200);
    h = 0;
    while (sclk && h < 100) begin
      if (h > 0 && (rise || fall)) sok = 0;
      h++;
      @(negedge clk);
    end
    if (!fall) sok = 0;
    l = 0;
    while (!sclk && l < 100) begin
      if (l > 0 && (rise || fall)) sok = 0;
      l++;
      @(negedge clk);
    end
    if (!rise) sok = 0;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    int h, l, sok;
    // R4 reset state
    #1;
    check("R4 sclk in reset", int'(sclk), 0);
    power_on();
    check("R4 div_code default", int'(div_code), 14);
    check("R4 boot_flag default", int'(boot_flag), 0);
    @(negedge clk);
    soft_rst = 1'b0;
    measure(h, l, sok);
    check("R4 default high", h, 34);
    check("R4 default low", l, 33);

    foreach (VEC[i]) begin
      logic [3:0] c;
      int eh, el;
      c  = VEC[i][15:12];
      eh = int'(VEC[i][11:6]);
      el = int'(VEC[i][5:0]);
      power_on();
      write_cfg({1'b0, c});
      soft_rst = 1'b0;
      if (eh == 0) begin
        repeat (3) begin
          @(negedge clk);
          check("R1 bypass low half", int'(sclk), 0);
          check("R1 bypass strobes", int'(rise && fall), 1);
          @(posedge clk); #2;
          check("R1 bypass high half", int'(sclk), 1);
        end
      end else begin
        measure(h, l, sok);
        check(c > 4'h7 ? "R3 high ticks" : "R2 high ticks", h, eh);
        check(c > 4'h7 ? "R3 low ticks" : "R2 low ticks", l, el);
        check("R9 strobe placement", sok, 1);
        if (c == 4'hF) check("R7 reserved stored", int'(div_code), 14);
      end
    end

    // R5 write-once, R6 companion bit
    power_on();
    write_cfg(5'b1_0011);
    write_cfg(5'b0_0101);
    soft_rst = 1'b0;
    check("R5 second write ignored", int'(div_code), 3);
    check("R6 boot_flag stored", int'(boot_flag), 1);
    measure(h, l, sok);
    check("R5 timing keeps first code", h * 100 + l, 202);

    // R10 soft reset restart, R5 retention
    @(negedge clk);
    soft_rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R10 sclk low in soft reset", int'(sclk), 0);
    end
    soft_rst = 1'b0;
    @(negedge clk);
    check("R10 rise after release", int'(sclk && rise), 1);
    check("R5 soft reset keeps code", int'(div_code), 3);
    check("R5 soft reset keeps flag", int'(boot_flag), 1);

    // R5 power-on reopens the register
    power_on();
    check("R5 por restores default", int'(div_code), 14);
    write_cfg(5'b0_0110);
    check("R5 write after por", int'(div_code), 6);

    // R8 code change in mid high phase
    power_on();
    @(negedge clk);
    soft_rst = 1'b0;
    begin
      int guard = 0;
      do begin @(negedge clk); guard++; end while (!rise && guard < 200);
    end
    h = 0;
    while (sclk && h < 100) begin
      h++;
      if (h == 5) begin wr_data = 5'b0_0001; wr_en = 1'b1; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    l = 0;
    while (!sclk && l < 100) begin l++; @(negedge clk); end
    check("R8 old high kept", h, 34);
    check("R8 old low kept", l, 33);
    h = 0;
    while (sclk && h < 100) begin h++; @(negedge clk); end
    check("R8 new code after low", h, 1);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule